// File: doc/BRIEF.md
# Adjustable Conversion Period Timer

This block paces the digital-to-analog and analog-to-digital conversions of a codec-style serial interface. Each direction, transmit and receive, has two counters in cascade. A prescale counter counts master-clock cycles. Each time it completes a pass, a period counter advances by one step. When the period counter expires, the block emits a one-cycle conversion strobe. The nominal conversion period is therefore the prescale length times the period count.

Every incoming 16-bit data word carries a sample in its upper fourteen bits, and the block latches that sample into a DAC holding register. The two lowest bits of the word are a control code. This code can stretch or shrink exactly one prescale pass by a signed trim value, which moves the sample phase without reprogramming the timing fields. The code can also ask for a secondary programming exchange, which the block signals on a single-cycle request output.

Top module: `conv_period_timer`

## Requirements
- R1: One clock edge after a `wordValid` cycle, `dacWord` equals bits 15..2 of that word, with bit 15 as its MSB. At all other times `dacWord` holds its value.
- R2: Code 2'b00 in word bits 1..0 leaves timing nominal. Successive pulses on `txConv` are `txPeriodA*txCountB` clock cycles apart, and successive pulses on `rxConv` are `rxPeriodA*rxCountB` cycles apart.
- R3: Code 2'b01 lengthens one prescale pass in each direction by its signed trim. `txTrimA` and `rxTrimA` are 6-bit two's complement values, so the affected conversion period changes by +trim cycles.
- R4: Code 2'b10 shortens one prescale pass in each direction by its signed trim, so the affected conversion period changes by -trim cycles.
- R5: Code 2'b11 keeps nominal timing and drives `secReq` high for exactly the one cycle after the `wordValid` cycle. A word with any other code leaves `secReq` low.
- R6: A trim affects only one prescale pass. Every later conversion period returns to the nominal length.
- R7: An adjusted prescale length of zero or less is clamped to 1 cycle. A prescale or period-count field of zero is treated as 1.
- R8: The code is latched on `wordValid` and takes effect at the next prescale reload. The pass that is running is not altered. If the strobe comes after the first pass has started, the trim lands inside the first full conversion period after reset.
- R9: While `rstN` is low, `txConv`, `rxConv`, `secReq` and `dacWord` are all 0. Both directions pulse their conversion strobe in the first cycle after the first clock edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Marks the cycle in which `wordIn` is valid |
| wordIn | input | 16 | Received data word: sample in bits 15..2, control code in bits 1..0 |
| txPeriodA | input | 6 | Transmit prescale length, unsigned |
| txTrimA | input | 6 | Transmit trim, two's complement |
| txCountB | input | 6 | Transmit prescale passes per conversion, unsigned |
| rxPeriodA | input | 6 | Receive prescale length, unsigned |
| rxTrimA | input | 6 | Receive trim, two's complement |
| rxCountB | input | 6 | Receive prescale passes per conversion, unsigned |
| dacWord | output | 14 | DAC holding register |
| secReq | output | 1 | One-cycle secondary-exchange request |
| txConv | output | 1 | Transmit conversion strobe |
| rxConv | output | 1 | Receive conversion strobe |

## Verification
The bench builds the block with its default 6-bit field width and 16-bit word. With these widths, negative trims such as 6'h3D can be driven directly. Small prescale and count values keep each conversion period within a few dozen cycles. This makes it possible to drive an adjusted sum down to zero or below and observe the one-cycle clamp. A zero period count can also be driven, and the resulting intervals can be measured pulse to pulse in both directions at once.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  typedef enum logic [1:0] {
    SEL_NOM   = 2'b00,
    SEL_LONG  = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_SEC   = 2'b11
  } reloadSel_e;

  typedef struct packed {
    logic       load;
    reloadSel_e sel;
  } ctpStrobes_t;
endpackage

// File: rtl/ctp_ctrl.sv
module ctp_ctrl
  import ctp_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DAC_W = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output ctpStrobes_t       ctl,
  output logic [DAC_W-1:0]  dacWord,
  output logic              secReq
);
  always_comb begin
    ctl.load = wordValid;
    ctl.sel  = reloadSel_e'(wordIn[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacWord <= '0;
      secReq  <= 1'b0;
    end else begin
      secReq <= wordValid && (wordIn[1:0] == 2'b11);
      if (wordValid) dacWord <= wordIn[WORD_W-1:2];
    end
  end

  a_r5_sec_only_after_code3: assert property (@(posedge clk) disable iff (!rstN)
    secReq |-> $past(wordValid) && ($past(wordIn[1:0]) == 2'b11));
  a_r1_dac_follows_word: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> dacWord == $past(wordIn[WORD_W-1:2]));
  a_r1_dac_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(dacWord));
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter
  import ctp_pkg::*;
#(
  parameter int CW = 6,
  localparam int CNT_W = CW + 1,
  localparam int SW = CW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctpStrobes_t   ctl,
  input  logic [CW-1:0] periodA,
  input  logic [CW-1:0] trimA,
  input  logic [CW-1:0] countB,
  output logic          conv
);
  logic [CNT_W-1:0] cntA;
  logic [CW-1:0]    cntB;
  reloadSel_e       pendSel;
  logic             aTerm;
  logic signed [SW-1:0] nomS, trimS, sumS;
  logic [CNT_W-1:0] reloadA;
  logic [CW-1:0]    reloadB;

  assign aTerm = (cntA == CNT_W'(1));

  always_comb begin
    nomS  = $signed({2'b00, periodA});
    trimS = $signed({{2{trimA[CW-1]}}, trimA});
    case (pendSel)
      SEL_LONG:  sumS = nomS + trimS;
      SEL_SHORT: sumS = nomS - trimS;
      default:   sumS = nomS;
    endcase
    if (sumS[SW-1] || (sumS == '0)) reloadA = CNT_W'(1);
    else                            reloadA = sumS[CNT_W-1:0];
    reloadB = (countB == '0) ? CW'(1) : countB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntA    <= CNT_W'(1);
      cntB    <= CW'(1);
      pendSel <= SEL_NOM;
      conv    <= 1'b0;
    end else begin
      conv <= aTerm && (cntB == CW'(1));
      if (aTerm) begin
        cntA    <= reloadA;
        pendSel <= ctl.load ? ctl.sel : SEL_NOM;
        if (cntB == CW'(1)) cntB <= reloadB;
        else                cntB <= cntB - CW'(1);
      end else begin
        cntA <= cntA - CNT_W'(1);
        if (ctl.load) pendSel <= ctl.sel;
      end
    end
  end

  a_r7_prescale_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    cntA != '0);
  a_r6_trim_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    (aTerm && !ctl.load) |=> pendSel == SEL_NOM);
  a_r8_no_mid_pass_change: assert property (@(posedge clk) disable iff (!rstN)
    (!aTerm && !ctl.load) |=> $stable(pendSel));
  a_r7_count_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    cntB != '0);
endmodule

// File: rtl/conv_period_timer.sv
module conv_period_timer
  import ctp_pkg::*;
#(
  parameter int CW = 6,
  parameter int WORD_W = 16,
  localparam int DAC_W = WORD_W - 2,
  localparam int NDIR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [CW-1:0]     txPeriodA,
  input  logic [CW-1:0]     txTrimA,
  input  logic [CW-1:0]     txCountB,
  input  logic [CW-1:0]     rxPeriodA,
  input  logic [CW-1:0]     rxTrimA,
  input  logic [CW-1:0]     rxCountB,
  output logic [DAC_W-1:0]  dacWord,
  output logic              secReq,
  output logic              txConv,
  output logic              rxConv
);
  ctpStrobes_t ctl;
  logic [CW-1:0] periodA [NDIR];
  logic [CW-1:0] trimA   [NDIR];
  logic [CW-1:0] countB  [NDIR];
  logic [NDIR-1:0] conv;

  assign periodA[0] = txPeriodA;
  assign trimA[0]   = txTrimA;
  assign countB[0]  = txCountB;
  assign periodA[1] = rxPeriodA;
  assign trimA[1]   = rxTrimA;
  assign countB[1]  = rxCountB;

  ctp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .ctl(ctl), .dacWord(dacWord), .secReq(secReq)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ctp_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rstN(rstN), .ctl(ctl),
      .periodA(periodA[d]), .trimA(trimA[d]), .countB(countB[d]),
      .conv(conv[d])
    );
  end

  assign txConv = conv[0];
  assign rxConv = conv[1];

  a_r9_idle_after_reset: assert property (@(posedge clk)
    $past(!rstN) && !rstN |-> !txConv && !rxConv && !secReq);
endmodule

// File: tb/conv_period_timer_bench.sv
module conv_period_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic [5:0] txPeriodA = '0, txTrimA = '0, txCountB = '0;
  logic [5:0] rxPeriodA = '0, rxTrimA = '0, rxCountB = '0;
  logic [13:0] dacWord;
  logic secReq, txConv, rxConv;

  int nChecks = 0;
  int nFails = 0;
  int txQ[$];
  int rxQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  conv_period_timer u_conv_period_timer (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .txPeriodA(txPeriodA), .txTrimA(txTrimA), .txCountB(txCountB),
    .rxPeriodA(rxPeriodA), .rxTrimA(rxTrimA), .rxCountB(rxCountB),
    .dacWord(dacWord), .secReq(secReq), .txConv(txConv), .rxConv(rxConv)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int atLeast1(input int v);
    return (v <= 0) ? 1 : v;
  endfunction

  function automatic int sx6(input logic [5:0] v);
    return v[5] ? int'(v) - 64 : int'(v);
  endfunction

  // Monitor: measures cycles between conversion pulses and pops expected intervals
  int cyc = 0;
  int txLast = 0, rxLast = 0;
  bit txHave = 0, rxHave = 0;
  string txTag = "R2", rxTag = "R2";
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      txHave = 0;
      rxHave = 0;
    end else begin
      if (txConv) begin
        if (txHave && txQ.size() > 0) check({txTag, " tx interval"}, cyc - txLast, txQ.pop_front());
        txHave = 1;
        txLast = cyc;
      end
      if (rxConv) begin
        if (rxHave && rxQ.size() > 0) check({rxTag, " rx interval"}, cyc - rxLast, rxQ.pop_front());
        rxHave = 1;
        rxLast = cyc;
      end
    end
  end

  // Driver: programs fields, resets, sends one word, pushes expected intervals
  task automatic scenario(input string tag, input logic [1:0] code, input logic [13:0] sample,
                          input logic [5:0] ta, input logic [5:0] tt, input logic [5:0] tb,
                          input logic [5:0] ra, input logic [5:0] rt, input logic [5:0] rb);
    int tNom, rNom, tAdj, rAdj, taE, raE;
    rstN = 1'b0;
    txPeriodA = ta; txTrimA = tt; txCountB = tb;
    rxPeriodA = ra; rxTrimA = rt; rxCountB = rb;
    txTag = tag; rxTag = tag;
    taE = atLeast1(ta); raE = atLeast1(ra);
    tNom = taE * atLeast1(tb);
    rNom = raE * atLeast1(rb);
    case (code)
      2'b01: begin tAdj = atLeast1(taE + sx6(tt)); rAdj = atLeast1(raE + sx6(rt)); end
      2'b10: begin tAdj = atLeast1(taE - sx6(tt)); rAdj = atLeast1(raE - sx6(rt)); end
      default: begin tAdj = taE; rAdj = raE; end
    endcase
    // R8/R3/R4: trim lands in the first full period; R6: later periods nominal
    txQ.push_back(tNom - taE + tAdj); txQ.push_back(tNom); txQ.push_back(tNom);
    rxQ.push_back(rNom - raE + rAdj); rxQ.push_back(rNom); rxQ.push_back(rNom);
    repeat (3) @(negedge clk);
    check("R9 reset txConv", int'(txConv), 0);
    check("R9 reset secReq", int'(secReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 first tx pulse", int'(txConv), 1);
    check("R9 first rx pulse", int'(rxConv), 1);
    wordValid = 1'b1;
    wordIn = {sample, code};
    @(negedge clk);
    wordValid = 1'b0;
    wordIn = 16'hFFFF;
    check("R1 dac capture", int'(dacWord), int'(sample));
    check("R5 secReq pulse", int'(secReq), (code == 2'b11) ? 1 : 0);
    @(negedge clk);
    check("R5 secReq one cycle", int'(secReq), 0);
    check("R1 dac hold", int'(dacWord), int'(sample));
    wait (txQ.size() == 0 && rxQ.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset dacWord", int'(dacWord), 0);
    check("R9 reset rxConv", int'(rxConv), 0);
    scenario("R2", 2'b00, 14'h2AF3, 6'd5, 6'd2, 6'd3, 6'd4, 6'd3, 6'd2);
    scenario("R3", 2'b01, 14'h1234, 6'd5, 6'd2, 6'd3, 6'd4, 6'h3D, 6'd2);
    scenario("R4", 2'b10, 14'h3FFF, 6'd4, 6'h3D, 6'd2, 6'd6, 6'd5, 6'd3);
    scenario("R7", 2'b10, 14'h0001, 6'd3, 6'd7, 6'd2, 6'd3, 6'd3, 6'd2);
    scenario("R5", 2'b11, 14'h2000, 6'd3, 6'd5, 6'd4, 6'd7, 6'd9, 6'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule